// File: doc/BRIEF.md
# PMBus Write Gate with Packet Error Checking

This block is the transaction-checking layer of a PMBus/SMBus slave. A byte-level I2C engine in front of it hands over every byte seen on the bus: the address byte after each start or repeated start, bytes written by the master, and bytes the slave itself sends during reads. It also signals each stop condition. The block runs a CRC-8 packet error code over each transaction addressed to it. It works out the expected length of every write from the command code, and decides at the end of the segment whether the write may be committed to the register file.

Writes that are malformed, that address an unsupported command, or that fail the error check when checking is required are dropped and raise a sticky communication-fault flag, which also drives an active-low alert line. For reads, the running code is presented so that the engine can send it as the byte after the data. The byte input is a valid/ready stream. The block never applies back-pressure: `s_ready` is held high, and each cycle with `s_valid` high moves exactly one byte.

Top module: `pmbus_write_gate`

## Requirements
- R1: After reset `commit` and `cml_status` are 0, `alert_n` is 1 and `pec_valid` is 0.
- R2: An address byte (bits 7:1 address, bit 0 = 1 for read) is acted on when its address equals `dev_addr`, 0x5A or 0x5B. Any other address produces no commit and no fault.
- R3: The length of a write follows from the command code. Codes 00xxxxxx take no data, 01xxxxxx take one byte and 10xxxxxx take two bytes. Codes 110xxxxx are block writes: a count byte N with 1 <= N <= MAX_BYTES-1 is followed by N bytes, giving a length of N+1. The length reported with a commit never exceeds MAX_BYTES.
- R4: An accepted write raises `commit` for exactly one cycle, the cycle after the one in which `bus_stop` is high. The commit carries `commit_cmd`, `commit_len` (data bytes without PEC) and `commit_data`, with data byte i in bits [8i+7:8i].
- R5: The PEC is CRC-8 with polynomial x^8+x^2+x+1 and initial value 0. It is taken over the address byte, the command and the data. If the master sends one byte beyond the expected length, that byte is checked as a PEC. A mismatch drops the write and raises a fault, whether or not PEC is required.
- R6: With `pec_required` high, a write without a PEC byte is dropped and raises a fault, and a write with a correct PEC commits.
- R7: A write with fewer bytes than its command needs, with more than one byte beyond that length, or with an out-of-range block count is dropped and raises a fault.
- R8: A write or a read whose command code is 111xxxxx raises a fault.
- R9: A repeated start with a matching read address, directly after the command byte, enters the read phase with `pec_valid` high. `pec_byte` then equals the CRC over the write address, the command, the read address and all bytes the slave has sent so far.
- R10: `cml_status` and a low `alert_n` remain set until an accepted write of command 0x03 (no data), which clears both in the same cycle that its `commit` appears.
- R11: In a group transaction with several address segments, an accepted segment for this device commits only at the final stop, not at the following repeated start.
- R12: `s_ready` is always 1, and a byte is taken in every cycle with `s_valid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | 7 | Configured device address |
| pec_required | input | 1 | Writes need a correct PEC before commit |
| s_valid | input | 1 | Byte stream valid |
| s_ready | output | 1 | Byte stream ready (always 1) |
| s_data | input | 8 | Bus byte |
| s_start | input | 1 | Byte is an address after a start or repeated start |
| s_from_slave | input | 1 | Byte was sent by this slave (read data or PEC) |
| bus_stop | input | 1 | Stop condition seen, one-cycle pulse |
| commit | output | 1 | Write-commit strobe |
| commit_cmd | output | 8 | Command code of the committed write |
| commit_len | output | LEN_W | Number of committed data bytes |
| commit_data | output | 8*MAX_BYTES | Committed data, byte 0 lowest |
| pec_valid | output | 1 | Read phase active, `pec_byte` usable |
| pec_byte | output | 8 | Running PEC for the read response |
| cml_status | output | 1 | Sticky communication-fault flag |
| alert_n | output | 1 | Active-low alert |

## Verification
The assertions assume a well-formed engine. `s_start` is only set together with an address byte, `bus_stop` is never high in the same cycle as `s_valid`, and at most one stop arrives between two address bytes. The bench keeps to this by passing every byte and every stop through tasks that drive one item per cycle, each followed by an idle cycle. It never overlaps a stop with a byte. Group and read sequences are built only from these same tasks.

// File: rtl/pmbus_gate_pkg.sv
package pmbus_gate_pkg;

  typedef enum logic [1:0] {
    SEG_IDLE,
    SEG_WR,
    SEG_RD,
    SEG_SKIP
  } seg_state_t;

  // One byte of CRC-8, polynomial 0x07, MSB first.
  function automatic logic [7:0] crc8_step(input logic [7:0] crc_in, input logic [7:0] din);
    logic [7:0] c;
    c = crc_in ^ din;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/pmbus_pec_crc.sv
module pmbus_pec_crc
  import pmbus_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       advance,
  input  logic [7:0] din,
  output logic [7:0] crc
);

  logic [7:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= 8'h00;
    else if (restart) crc_q <= crc8_step(8'h00, din);
    else if (advance) crc_q <= crc8_step(crc_q, din);
  end

  assign crc = crc_q;

endmodule

// File: rtl/pmbus_cmd_decode.sv
module pmbus_cmd_decode #(
  parameter int MAX_BYTES = 4,
  parameter int LEN_W     = $clog2(MAX_BYTES + 3)
) (
  input  logic [7:0]       cmd,
  input  logic [7:0]       first_data,
  output logic             supported,
  output logic             count_ok,
  output logic [LEN_W-1:0] n_exp
);

  localparam logic [7:0] BLK_MAX = 8'(MAX_BYTES - 1);

  always_comb begin
    supported = 1'b1;
    count_ok  = 1'b1;
    n_exp     = '0;
    unique case (cmd[7:6])
      2'b00: n_exp = LEN_W'(0);
      2'b01: n_exp = LEN_W'(1);
      2'b10: n_exp = LEN_W'(2);
      default: begin
        if (cmd[5]) begin
          supported = 1'b0;
        end else if (first_data == 8'h00 || first_data > BLK_MAX) begin
          count_ok = 1'b0;
        end else begin
          n_exp = LEN_W'(first_data) + LEN_W'(1);
        end
      end
    endcase
  end

endmodule

// File: rtl/pmbus_fault_flag.sv
module pmbus_fault_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic cml,
  output logic alert_n
);

  logic cml_q, alert_n_q;
  logic cml_d;

  always_comb begin
    cml_d = cml_q;
    if (clr) cml_d = 1'b0;
    if (set) cml_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cml_q     <= 1'b0;
      alert_n_q <= 1'b1;
    end else begin
      cml_q     <= cml_d;
      alert_n_q <= ~cml_d;
    end
  end

  assign cml     = cml_q;
  assign alert_n = alert_n_q;

  // R10: fault flag holds until a clear arrives
  p_cml_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cml && !clr) |=> cml);

  // R10: an accepted clear with no new fault drops the flag and the alert
  p_cml_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> (!cml && alert_n));

endmodule

// File: rtl/pmbus_write_gate.sv
module pmbus_write_gate
  import pmbus_gate_pkg::*;
#(
  parameter int         MAX_BYTES     = 4,
  parameter logic [7:0] CLEAR_CMD     = 8'h03,
  parameter logic [6:0] GLOBAL_ADDR_A = 7'h5A,
  parameter logic [6:0] GLOBAL_ADDR_B = 7'h5B,
  parameter int         LEN_W         = $clog2(MAX_BYTES + 3)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [6:0]             dev_addr,
  input  logic                   pec_required,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic [7:0]             s_data,
  input  logic                   s_start,
  input  logic                   s_from_slave,
  input  logic                   bus_stop,
  output logic                   commit,
  output logic [7:0]             commit_cmd,
  output logic [LEN_W-1:0]       commit_len,
  output logic [8*MAX_BYTES-1:0] commit_data,
  output logic                   pec_valid,
  output logic [7:0]             pec_byte,
  output logic                   cml_status,
  output logic                   alert_n
);

  localparam logic [LEN_W-1:0] CNT_MAX = LEN_W'(MAX_BYTES + 2);
  localparam logic [LEN_W-1:0] LEN_LIM = LEN_W'(MAX_BYTES);

  seg_state_t             state_q;
  logic [7:0]             cmd_q;
  logic                   cmd_seen_q;
  logic [LEN_W-1:0]       cnt_q;
  logic [8*MAX_BYTES-1:0] buf_q;
  logic                   pend_q;
  logic                   commit_q;
  logic [7:0]             commit_cmd_q;
  logic [LEN_W-1:0]       commit_len_q;
  logic [8*MAX_BYTES-1:0] commit_data_q;

  logic [7:0]       crc;
  logic             supported, count_ok;
  logic [LEN_W-1:0] n_exp;

  logic addr_ev, data_ev, rw, addr_hit;
  logic to_read, start_wr, closing, close_wr, close_rd;
  logic exact_len, has_pec, wr_ok, accept, fault_set, fault_clr;
  logic crc_adv;

  assign s_ready  = 1'b1;
  assign addr_ev  = s_valid & s_start;
  assign data_ev  = s_valid & ~s_start;
  assign rw       = s_data[0];
  assign addr_hit = (s_data[7:1] == dev_addr) || (s_data[7:1] == GLOBAL_ADDR_A) ||
                    (s_data[7:1] == GLOBAL_ADDR_B);

  pmbus_cmd_decode #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_dec (
    .cmd       (cmd_q),
    .first_data(buf_q[7:0]),
    .supported (supported),
    .count_ok  (count_ok),
    .n_exp     (n_exp)
  );

  // Segment decisions
  assign to_read   = addr_ev & rw & addr_hit & (state_q == SEG_WR) & cmd_seen_q & (cnt_q == '0);
  assign start_wr  = addr_ev & ~rw & addr_hit;
  assign closing   = (addr_ev & ~to_read) | bus_stop;
  assign close_wr  = closing & (state_q == SEG_WR) & cmd_seen_q;
  assign close_rd  = closing & (state_q == SEG_RD);
  assign exact_len = (cnt_q == n_exp);
  assign has_pec   = (cnt_q == n_exp + LEN_W'(1));
  assign wr_ok     = supported & count_ok &
                     ((exact_len & ~pec_required) | (has_pec & (crc == 8'h00)));
  assign accept    = close_wr & wr_ok;
  assign fault_set = (close_wr & ~wr_ok) | (close_rd & ~supported);
  assign fault_clr = accept & (cmd_q == CLEAR_CMD);
  assign crc_adv   = (data_ev & ((state_q == SEG_WR) | (state_q == SEG_RD))) | to_read;

  pmbus_pec_crc u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(start_wr),
    .advance(crc_adv),
    .din    (s_data),
    .crc    (crc)
  );

  pmbus_fault_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (fault_set),
    .clr    (fault_clr),
    .cml    (cml_status),
    .alert_n(alert_n)
  );

  // Segment state, command capture and byte count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEG_IDLE;
      cmd_q      <= 8'h00;
      cmd_seen_q <= 1'b0;
      cnt_q      <= '0;
    end else if (bus_stop) begin
      state_q <= SEG_IDLE;
    end else if (addr_ev) begin
      if (start_wr) begin
        state_q    <= SEG_WR;
        cmd_seen_q <= 1'b0;
        cnt_q      <= '0;
      end else if (to_read) begin
        state_q <= SEG_RD;
      end else begin
        state_q <= SEG_SKIP;
      end
    end else if (data_ev && state_q == SEG_WR) begin
      if (!cmd_seen_q) begin
        cmd_q      <= s_data;
        cmd_seen_q <= 1'b1;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
    end
  end

  // Data byte buffer, one lane per byte position
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (data_ev && state_q == SEG_WR && cmd_seen_q) begin
      for (int i = 0; i < MAX_BYTES; i++) begin
        if (cnt_q == LEN_W'(i)) buf_q[8*i +: 8] <= s_data;
      end
    end
  end

  // Commit capture at segment close, strobe at stop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q        <= 1'b0;
      commit_q      <= 1'b0;
      commit_cmd_q  <= 8'h00;
      commit_len_q  <= '0;
      commit_data_q <= '0;
    end else begin
      commit_q <= bus_stop & (pend_q | accept);
      if (bus_stop)    pend_q <= 1'b0;
      else if (accept) pend_q <= 1'b1;
      if (accept) begin
        commit_cmd_q  <= cmd_q;
        commit_len_q  <= n_exp;
        commit_data_q <= buf_q;
      end
    end
  end

  assign commit      = commit_q;
  assign commit_cmd  = commit_cmd_q;
  assign commit_len  = commit_len_q;
  assign commit_data = commit_data_q;
  assign pec_valid   = (state_q == SEG_RD);
  assign pec_byte    = crc;

  // R4: a commit only ever follows a stop
  p_commit_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(bus_stop));

  // R4: commit strobe lasts one cycle
  p_commit_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  // R3: committed length stays within the buffer
  p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (commit_len <= LEN_LIM));

  // R9: the read phase never coincides with a commit
  p_read_no_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pec_valid |-> !commit);

endmodule

// File: tb/pmbus_write_gate_tb.sv
module pmbus_write_gate_tb;

  localparam int MAXB = 4;
  localparam int LW   = $clog2(MAXB + 3);
  localparam logic [6:0] DEV = 7'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] dev_addr = DEV;
  logic pec_required = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [7:0] s_data = 8'h00;
  logic s_start = 1'b0;
  logic s_from_slave = 1'b0;
  logic bus_stop = 1'b0;
  logic commit;
  logic [7:0] commit_cmd;
  logic [LW-1:0] commit_len;
  logic [8*MAXB-1:0] commit_data;
  logic pec_valid;
  logic [7:0] pec_byte;
  logic cml_status;
  logic alert_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] run_crc;

  always #5 clk = ~clk;

  pmbus_write_gate #(.MAX_BYTES(MAXB)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .pec_required(pec_required),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_start(s_start),
    .s_from_slave(s_from_slave), .bus_stop(bus_stop), .commit(commit),
    .commit_cmd(commit_cmd), .commit_len(commit_len), .commit_data(commit_data),
    .pec_valid(pec_valid), .pec_byte(pec_byte), .cml_status(cml_status), .alert_n(alert_n)
  );

  // Bitwise shift-in form of CRC-8, polynomial 0x07
  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      fb = r[7] ^ d[b];
      r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  typedef struct packed {
    logic [6:0]  addr;
    logic [7:0]  cmd;
    logic [2:0]  nd;
    logic [31:0] data;
    logic [1:0]  pec;   // 0 none, 1 good, 2 bad
    logic        req;
    logic        exp_commit;
    logic        exp_fault;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{7'h40, 8'h41, 3'd1, 32'h000000A5, 2'd0, 1'b0, 1'b1, 1'b0}, // R3 R4 byte write
    '{7'h5A, 8'h82, 3'd2, 32'h00001234, 2'd0, 1'b0, 1'b1, 1'b0}, // R2 global A, word
    '{7'h5B, 8'h02, 3'd0, 32'h00000000, 2'd1, 1'b0, 1'b1, 1'b0}, // R2 R5 global B, send + PEC
    '{7'h41, 8'h41, 3'd1, 32'h00000077, 2'd0, 1'b0, 1'b0, 1'b0}, // R2 foreign address
    '{7'h40, 8'h41, 3'd1, 32'h00000019, 2'd2, 1'b0, 1'b0, 1'b1}, // R5 bad PEC
    '{7'h40, 8'h82, 3'd2, 32'h0000BEEF, 2'd0, 1'b1, 1'b0, 1'b1}, // R6 missing PEC
    '{7'h40, 8'h82, 3'd2, 32'h0000CAFE, 2'd1, 1'b1, 1'b1, 1'b0}, // R6 good PEC
    '{7'h40, 8'h82, 3'd1, 32'h00000011, 2'd0, 1'b0, 1'b0, 1'b1}, // R7 too short
    '{7'h40, 8'h41, 3'd3, 32'h00332211, 2'd0, 1'b0, 1'b0, 1'b1}, // R7 too long
    '{7'h40, 8'hC5, 3'd3, 32'h00221102, 2'd0, 1'b0, 1'b1, 1'b0}, // R3 block, count 2
    '{7'h40, 8'hC5, 3'd4, 32'h03020104, 2'd0, 1'b0, 1'b0, 1'b1}, // R7 block count too large
    '{7'h40, 8'hE0, 3'd1, 32'h00000055, 2'd0, 1'b0, 1'b0, 1'b1}  // R8 unsupported write
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic st, input logic fs);
    @(negedge clk);
    s_valid = 1'b1; s_data = b; s_start = st; s_from_slave = fs;
    run_crc = st && !b[0] ? ref_crc(8'h00, b) : ref_crc(run_crc, b);
    @(negedge clk);
    s_valid = 1'b0; s_start = 1'b0; s_from_slave = 1'b0;
  endtask

  task automatic stop();
    @(negedge clk);
    bus_stop = 1'b1;
    @(negedge clk);
    bus_stop = 1'b0;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] c, input int nd,
                          input logic [31:0] d, input int pm);
    logic [7:0] p;
    send({a, 1'b0}, 1'b1, 1'b0);
    send(c, 1'b0, 1'b0);
    for (int i = 0; i < nd; i++) send(d[8*i +: 8], 1'b0, 1'b0);
    p = run_crc;
    if (pm == 1) send(p, 1'b0, 1'b0);
    if (pm == 2) send(p ^ 8'h01, 1'b0, 1'b0);
    stop();
  endtask

  task automatic clear_faults();
    do_write(DEV, 8'h03, 0, 32'h0, 1);
    chk("R10 clear cml", {63'd0, cml_status}, 64'd0);
    chk("R10 clear alert_n", {63'd0, alert_n}, 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    run_crc = 8'h00;
    repeat (3) @(negedge clk);
    // R1 and R12: state straight out of reset
    chk("R1 commit", {63'd0, commit}, 64'd0);
    chk("R1 cml", {63'd0, cml_status}, 64'd0);
    chk("R1 alert_n", {63'd0, alert_n}, 64'd1);
    chk("R1 pec_valid", {63'd0, pec_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 s_ready", {63'd0, s_ready}, 64'd1);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] mask;
      pec_required = VECS[v].req;
      do_write(VECS[v].addr, VECS[v].cmd, int'(VECS[v].nd), VECS[v].data, int'(VECS[v].pec));
      chk($sformatf("vector %0d commit", v), {63'd0, commit}, {63'd0, VECS[v].exp_commit});
      chk($sformatf("vector %0d cml", v), {63'd0, cml_status}, {63'd0, VECS[v].exp_fault});
      if (VECS[v].exp_commit) begin
        mask = (VECS[v].nd == 3'd4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * VECS[v].nd)) - 32'd1);
        chk($sformatf("vector %0d R4 cmd", v), {56'd0, commit_cmd}, {56'd0, VECS[v].cmd});
        chk($sformatf("vector %0d R4 len", v), {{(64-LW){1'b0}}, commit_len}, {61'd0, VECS[v].nd});
        chk($sformatf("vector %0d R4 data", v), {32'd0, commit_data & mask}, {32'd0, VECS[v].data & mask});
        @(negedge clk);
        chk($sformatf("vector %0d R4 single pulse", v), {63'd0, commit}, 64'd0);
      end
      pec_required = 1'b0;
      if (VECS[v].exp_fault) clear_faults();
    end

    // R9: read response PEC
    send({DEV, 1'b0}, 1'b1, 1'b0);
    send(8'h41, 1'b0, 1'b0);
    send({DEV, 1'b1}, 1'b1, 1'b0);
    chk("R9 pec_valid", {63'd0, pec_valid}, 64'd1);
    send(8'h3C, 1'b0, 1'b1);
    chk("R9 pec_byte", {56'd0, pec_byte}, {56'd0, run_crc});
    send(run_crc, 1'b0, 1'b1);
    stop();
    chk("R9 no commit on read", {63'd0, commit}, 64'd0);
    chk("R9 no fault on read", {63'd0, cml_status}, 64'd0);
    chk("R9 pec_valid after stop", {63'd0, pec_valid}, 64'd0);

    // R8: read of an unsupported command
    send({DEV, 1'b0}, 1'b1, 1'b0);
    send(8'hF0, 1'b0, 1'b0);
    send({DEV, 1'b1}, 1'b1, 1'b0);
    send(8'h00, 1'b0, 1'b1);
    stop();
    chk("R8 unsupported read cml", {63'd0, cml_status}, 64'd1);

    // R10: flag and alert persist over a good write
    do_write(DEV, 8'h41, 1, 32'h0000005A, 0);
    chk("R10 sticky commit ok", {63'd0, commit}, 64'd1);
    chk("R10 sticky cml", {63'd0, cml_status}, 64'd1);
    chk("R10 sticky alert_n", {63'd0, alert_n}, 64'd0);
    clear_faults();

    // R11: group transaction, own segment in the middle
    send(8'h44, 1'b1, 1'b0);
    send(8'h41, 1'b0, 1'b0);
    send(8'h99, 1'b0, 1'b0);
    send({DEV, 1'b0}, 1'b1, 1'b0);
    send(8'h41, 1'b0, 1'b0);
    send(8'h5C, 1'b0, 1'b0);
    send(8'h46, 1'b1, 1'b0);
    chk("R11 no commit at repeated start", {63'd0, commit}, 64'd0);
    send(8'h10, 1'b0, 1'b0);
    chk("R11 no commit before stop", {63'd0, commit}, 64'd0);
    stop();
    chk("R11 commit at stop", {63'd0, commit}, 64'd1);
    chk("R11 cmd", {56'd0, commit_cmd}, 64'h41);
    chk("R11 data", {56'd0, commit_data[7:0]}, 64'h5C);
    chk("R11 no fault", {63'd0, cml_status}, 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule